// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

This block joins two eight-line priority interrupt controllers into one unit. One is the primary controller and the other is the secondary. A byte-wide port bus reaches both. Each controller has two ports: a command port at an even address and a data port at the next odd address. By default the primary uses 0x20/0x21 and the secondary uses 0xA0/0xA1. Software programs each controller with a short setup sequence. The first word goes to the command port. Then one, two or three words go to the data port, and the bits of the first word decide how many. After setup, software sets per-line masks, ends service on lines, and can read back the in-service set once.

Sixteen request lines come in. Lines 0–7 belong to the primary controller. Lines 8–15 are lines 0–7 of the secondary. The unit accepts at most one request per clock, always the lowest-numbered eligible line. It marks that line in service and raises `vec_valid` for one cycle. While `vec_valid` is high, `vec_num` carries the line's vector. A line that cannot be taken is refused. It is not remembered. A line whose request is held high is taken again once it becomes eligible.

Top module: `dual_irq_ctrl`

## Requirements
- R1: A command-port write with bit 4 = 1 starts setup. It latches bits 1:0 of the byte as configuration, and the following data-port writes are consumed as setup words, so the mask keeps its value.
- R2: The first setup data word becomes the vector base with bits 2:0 forced to 0. An accepted line n produces vector base + n.
- R3: If configuration bit 1 = 1 (single) and bit 0 = 0 (no fourth word), setup ends after the base word, and the next data write loads the mask.
- R4: If configuration bit 1 = 0, the word after the base is stored as the cascade word. Setup ends there when configuration bit 0 = 0.
- R5: Otherwise a fourth data word follows and always ends setup. Its bit 1 sets automatic end-of-service on (1) or off (0).
- R6: Outside setup, a data-port write loads the mask. A data-port read returns the mask. A line whose mask bit is 1 is never accepted.
- R7: A command write with bit 4 = 0 and bit 3 = 1 has an effect only for the value 0x0B. That value makes the next command-port read return the in-service byte once. Every other command-port read returns 0.
- R8: A command write with bits 4 and 3 = 0 and bit 5 = 1 ends service. With bit 6 = 1 it clears only the in-service bit selected by bits 2:0. With bit 6 = 0 it clears all in-service bits.
- R9: A request on a primary line is refused if that line is already in service or if its bit is set in the primary cascade word. Otherwise the line's in-service bit is set, and `vec_valid` pulses in the cycle after the sampling clock edge.
- R10: Secondary lines are accepted only while primary cascade-word bit 2 is 1 and the secondary cascade word equals exactly 2. The same busy and cascade refusals then apply, and the vector comes from the secondary base.
- R11: With automatic end-of-service on, the accepted line's in-service bit clears at the clock edge that ends its `vec_valid` pulse.
- R12: When several lines are eligible at one edge, the lowest-numbered line wins. Lines 0–7 therefore beat lines 8–15.
- R13: After reset both masks, both in-service sets and both cascade words are 0, no setup is in progress, automatic end-of-service is off, and `vec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Port address for a read or a write |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_lines | input | 16 | Request lines, sampled on every rising edge |
| vec_valid | output | 1 | One-cycle pulse for an accepted request |
| vec_num | output | 8 | Vector of the accepted request |

## Verification
The assertions assume that a read and a write never share a cycle, and that a cascade word is not rewritten at the same edge that accepts a request. The bench drives every bus access as a single isolated one-cycle strobe, leaves a gap before the next one, and only re-runs setup while all request lines are low. The bench's behavioural model checks `vec_valid` and `vec_num` on every cycle. It is fed the same stimulus, so held and simultaneous requests are scored exactly.

// File: rtl/dpic_pkg.sv
package dpic_pkg;

   localparam int unsigned LINES_PER_UNIT = 8;
   localparam int unsigned LINE_W         = $clog2(LINES_PER_UNIT);

   // command byte decode positions
   localparam int unsigned CMD_SETUP_BIT = 4;
   localparam int unsigned CMD_QUERY_BIT = 3;
   localparam int unsigned CMD_EOS_BIT   = 5;
   localparam int unsigned CMD_ONE_BIT   = 6;
   localparam logic [7:0]  CMD_ISR_ARM   = 8'h0B;

   // latched configuration bits
   localparam int unsigned CFG_NEED4_BIT  = 0;
   localparam int unsigned CFG_SINGLE_BIT = 1;
   localparam int unsigned W4_AUTO_BIT    = 1;

   typedef logic [7:0] byte_t;

   typedef enum logic [1:0] {
      PH_RUN  = 2'd0,
      PH_BASE = 2'd1,
      PH_CASC = 2'd2,
      PH_W4   = 2'd3
   } setup_phase_e;

endpackage

// File: rtl/dpic_unit.sv
module dpic_unit
   import dpic_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmd_wr_i,
   input  logic              dat_wr_i,
   input  logic              cmd_rd_i,
   input  byte_t             wdata_i,
   input  logic [LINES_PER_UNIT-1:0] req_i,
   input  logic              take_i,
   input  logic [LINE_W-1:0] take_line_i,
   input  logic              drop_i,
   input  logic [LINE_W-1:0] drop_line_i,
   output logic [LINES_PER_UNIT-1:0] elig_o,
   output byte_t             base_o,
   output byte_t             casc_o,
   output logic              auto_o,
   output byte_t             cmd_rdata_o,
   output byte_t             dat_rdata_o
);

   setup_phase_e phase_q;
   logic [1:0]   cfg_q;
   byte_t        mask_q, isr_q, base_q, casc_q;
   logic         auto_q, armed_q;

   logic         is_setup_cmd, is_query_cmd, is_eos_cmd;
   byte_t        eos_clr, set_bits, drop_bits;

   assign is_setup_cmd = cmd_wr_i && wdata_i[CMD_SETUP_BIT];
   assign is_query_cmd = cmd_wr_i && !wdata_i[CMD_SETUP_BIT] && wdata_i[CMD_QUERY_BIT];
   assign is_eos_cmd   = cmd_wr_i && !wdata_i[CMD_SETUP_BIT] && !wdata_i[CMD_QUERY_BIT]
                         && wdata_i[CMD_EOS_BIT];

   always_comb begin
      eos_clr = '0;
      if (is_eos_cmd) begin
         if (wdata_i[CMD_ONE_BIT]) eos_clr[wdata_i[LINE_W-1:0]] = 1'b1;
         else                      eos_clr = '1;
      end
      set_bits = '0;
      if (take_i) set_bits[take_line_i] = 1'b1;
      drop_bits = '0;
      if (drop_i) drop_bits[drop_line_i] = 1'b1;
   end

   // setup sequencer, mask and cascade word
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_RUN;
         cfg_q   <= '0;
         mask_q  <= '0;
         base_q  <= '0;
         casc_q  <= '0;
         auto_q  <= 1'b0;
      end else if (is_setup_cmd) begin
         phase_q <= PH_BASE;
         cfg_q   <= wdata_i[1:0];
      end else if (dat_wr_i) begin
         unique case (phase_q)
            PH_RUN: mask_q <= wdata_i;
            PH_BASE: begin
               base_q <= {wdata_i[7:LINE_W], {LINE_W{1'b0}}};
               if (cfg_q[CFG_SINGLE_BIT] && !cfg_q[CFG_NEED4_BIT]) phase_q <= PH_RUN;
               else if (!cfg_q[CFG_SINGLE_BIT])                  phase_q <= PH_CASC;
               else                                               phase_q <= PH_W4;
            end
            PH_CASC: begin
               casc_q  <= wdata_i;
               phase_q <= cfg_q[CFG_NEED4_BIT] ? PH_W4 : PH_RUN;
            end
            PH_W4: begin
               auto_q  <= wdata_i[W4_AUTO_BIT];
               phase_q <= PH_RUN;
            end
            default: phase_q <= PH_RUN;
         endcase
      end
   end

   // in-service set and one-shot readback flag
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         isr_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         isr_q <= (isr_q & ~eos_clr & ~drop_bits) | set_bits;
         if (is_query_cmd && wdata_i == CMD_ISR_ARM) armed_q <= 1'b1;
         else if (cmd_rd_i)                          armed_q <= 1'b0;
      end
   end

   assign elig_o      = req_i & ~mask_q & ~isr_q & ~casc_q;
   assign base_o      = base_q;
   assign casc_o      = casc_q;
   assign auto_o      = auto_q;
   assign cmd_rdata_o = armed_q ? isr_q : '0;
   assign dat_rdata_o = mask_q;

   assert_take_marks_isr_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |=> isr_q[$past(take_line_i)]);

   assert_auto_clear_R11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop_i |=> !isr_q[$past(drop_line_i)]);

   assert_readback_once_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_rd_i && !cmd_wr_i) |=> (cmd_rdata_o == 8'h00));

   assert_masked_never_taken_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |-> !mask_q[take_line_i]);

endmodule

// File: rtl/dpic_prio.sv
module dpic_prio #(
   parameter int unsigned N = 16,
   localparam int unsigned IDX_W = $clog2(N)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [N-1:0]     grant_o
);

   if (N < 2) begin : g_bad_n
      $error("dpic_prio: N must be at least 2");
   end

   always_comb begin
      idx_o   = '0;
      grant_o = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req_i[k]) begin
            idx_o   = IDX_W'(k);
            grant_o = N'(1) << k;
         end
      end
   end

   assign any_o = |req_i;

   assert_single_grant_R12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(grant_o));

   assert_lowest_wins_R12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_o |-> ((req_i & (grant_o - N'(1))) == '0));

endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
   import dpic_pkg::*;
#(
   parameter int unsigned ADDR_W        = 8,
   parameter logic [ADDR_W-1:0] PRI_PORT = 8'h20,
   parameter logic [ADDR_W-1:0] SEC_PORT = 8'hA0,
   parameter int unsigned CASC_LINE     = 2,
   localparam int unsigned UNITS        = 2,
   localparam int unsigned ALL_LINES    = UNITS * LINES_PER_UNIT,
   localparam int unsigned IDX_W        = $clog2(ALL_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [15:0]       irq_lines,
   output logic              vec_valid,
   output logic [7:0]        vec_num
);

   if (CASC_LINE >= LINES_PER_UNIT) begin : g_bad_casc
      $error("dual_irq_ctrl: CASC_LINE out of range");
   end
   if (PRI_PORT[0] || SEC_PORT[0]) begin : g_bad_port
      $error("dual_irq_ctrl: command ports must be even");
   end
   if (PRI_PORT == SEC_PORT) begin : g_same_port
      $error("dual_irq_ctrl: port bases must differ");
   end

   logic [LINES_PER_UNIT-1:0] elig   [UNITS];
   byte_t                     base   [UNITS];
   byte_t                     casc   [UNITS];
   logic                      auto_e [UNITS];
   byte_t                     cmd_rd [UNITS];
   byte_t                     dat_rd [UNITS];
   logic [UNITS-1:0]          hit_cmd, hit_dat;

   logic                 sec_gate;
   logic [ALL_LINES-1:0] elig_all, grant_all;
   logic                 arb_any;
   logic [IDX_W-1:0]     arb_idx;
   logic                 vec_valid_q;
   byte_t                vec_q;
   logic [IDX_W-1:0]     last_idx_q;

   for (genvar u = 0; u < UNITS; u++) begin : g_unit
      localparam logic [ADDR_W-1:0] CMD_A = (u == 0) ? PRI_PORT : SEC_PORT;
      localparam logic [ADDR_W-1:0] DAT_A = CMD_A | ADDR_W'(1);
      logic take_u, drop_u;

      assign hit_cmd[u] = (bus_addr == CMD_A);
      assign hit_dat[u] = (bus_addr == DAT_A);
      assign take_u = arb_any && (arb_idx[IDX_W-1] == 1'(u));
      assign drop_u = vec_valid_q && (last_idx_q[IDX_W-1] == 1'(u)) && auto_e[u];

      dpic_unit u_ctl (
         .clk_i       (clk),
         .rst_ni      (rst_n),
         .cmd_wr_i    (bus_wr && hit_cmd[u]),
         .dat_wr_i    (bus_wr && hit_dat[u]),
         .cmd_rd_i    (bus_rd && hit_cmd[u]),
         .wdata_i     (bus_wdata),
         .req_i       (irq_lines[u*LINES_PER_UNIT +: LINES_PER_UNIT]),
         .take_i      (take_u),
         .take_line_i (arb_idx[LINE_W-1:0]),
         .drop_i      (drop_u),
         .drop_line_i (last_idx_q[LINE_W-1:0]),
         .elig_o      (elig[u]),
         .base_o      (base[u]),
         .casc_o      (casc[u]),
         .auto_o      (auto_e[u]),
         .cmd_rdata_o (cmd_rd[u]),
         .dat_rdata_o (dat_rd[u])
      );
   end

   assign sec_gate = casc[0][CASC_LINE] && (casc[1] == 8'(CASC_LINE));
   assign elig_all = {elig[1] & {LINES_PER_UNIT{sec_gate}}, elig[0]};

   dpic_prio #(.N(ALL_LINES)) u_prio (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .req_i   (elig_all),
      .any_o   (arb_any),
      .idx_o   (arb_idx),
      .grant_o (grant_all)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_valid_q <= 1'b0;
         vec_q       <= '0;
         last_idx_q  <= '0;
      end else begin
         vec_valid_q <= arb_any;
         if (arb_any) begin
            vec_q      <= base[arb_idx[IDX_W-1]] | {5'b0, arb_idx[LINE_W-1:0]};
            last_idx_q <= arb_idx;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int u = 0; u < UNITS; u++) begin
         if (hit_cmd[u]) bus_rdata = cmd_rd[u];
         if (hit_dat[u]) bus_rdata = dat_rd[u];
      end
   end

   assign vec_valid = vec_valid_q;
   assign vec_num   = vec_q;

   assert_no_back_to_back_line_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid_q && $past(vec_valid_q)) |-> (last_idx_q != $past(last_idx_q)));

   assert_sec_needs_gate_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid_q && last_idx_q[IDX_W-1]) |-> (casc[0][CASC_LINE] && casc[1] == 8'(CASC_LINE)));

   assert_grant_matches_index_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      arb_any |-> grant_all[arb_idx]);

endmodule

// File: tb/dual_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_irq_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [15:0] irq_lines = '0;
   logic       vec_valid;
   logic [7:0] vec_num;

   int n_checks = 0, n_fail = 0, cycles = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dual_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
      .vec_valid(vec_valid), .vec_num(vec_num));

   // behavioural reference model
   int mk[2], is[2], bs[2], cw[2], cf[2], ph[2], au[2], ar[2];
   int ev = 0, evec = 0, eidx = 0;

   function automatic bit bitof(int v, int b);
      return ((v >> b) & 1) != 0;
   endfunction

   always @(posedge clk) begin
      int sel, u, l;
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) begin
            mk[k] = 0; is[k] = 0; bs[k] = 0; cw[k] = 0; cf[k] = 0; ph[k] = 0; au[k] = 0; ar[k] = 0;
         end
         ev = 0;
      end else begin
         sel = -1;
         for (int k = 0; k < 16; k++) begin
            u = k / 8; l = k % 8;
            if (sel < 0 && irq_lines[k] && !bitof(mk[u], l) && !bitof(is[u], l) && !bitof(cw[u], l)
                && (u == 0 || (bitof(cw[0], 2) && cw[1] == 2)))
               sel = k;
         end
         if (ev != 0 && au[eidx / 8] != 0) is[eidx / 8] &= ~(1 << (eidx % 8));
         u = (bus_addr[7:1] == 7'h10) ? 0 : 1;
         if (bus_wr && (bus_addr[7:1] == 7'h10 || bus_addr[7:1] == 7'h50)) begin
            if (!bus_addr[0]) begin
               if (bus_wdata[4]) begin ph[u] = 1; cf[u] = bus_wdata & 3; end
               else if (bus_wdata[3]) begin if (bus_wdata == 8'h0B) ar[u] = 1; end
               else if (bus_wdata[5]) begin
                  if (bus_wdata[6]) is[u] &= ~(1 << bus_wdata[2:0]);
                  else is[u] = 0;
               end
            end else begin
               case (ph[u])
                  0: mk[u] = bus_wdata;
                  1: begin
                     bs[u] = bus_wdata & 8'hF8;
                     if (bitof(cf[u], 1) && !bitof(cf[u], 0)) ph[u] = 0;
                     else if (!bitof(cf[u], 1)) ph[u] = 2;
                     else ph[u] = 3;
                  end
                  2: begin cw[u] = bus_wdata; ph[u] = bitof(cf[u], 0) ? 3 : 0; end
                  default: begin au[u] = bus_wdata[1]; ph[u] = 0; end
               endcase
            end
         end
         if (bus_rd && !bus_addr[0] && (bus_addr[7:1] == 7'h10 || bus_addr[7:1] == 7'h50)) ar[u] = 0;
         if (sel >= 0) begin
            is[sel / 8] |= 1 << (sel % 8);
            evec = (bs[sel / 8] + sel % 8) & 8'hFF;
            eidx = sel;
         end
         ev = (sel >= 0) ? 1 : 0;
      end
   end

   task automatic check(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-cycle comparison of the vector outputs (R9, R12)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(vec_valid == ev[0], "R9 vec_valid", vec_valid, ev);
         if (ev != 0) check(vec_num == evec[7:0], "R12 vec_num", vec_num, evec);
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      #1 check(bus_rdata == exp, req, bus_rdata, exp);
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic req(input logic [15:0] m, input int hold);
      @(negedge clk); irq_lines = m;
      repeat (hold) @(negedge clk);
      irq_lines = '0;
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=done", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R13 reset state
      rd_chk(8'h21, 8'h00, "R13 mask");
      rd_chk(8'h20, 8'h00, "R13 cmd read");
      check(vec_valid == 1'b0, "R13 vec_valid", vec_valid, 0);
      // R1 R2 R4 R5 setup both controllers, cascade, fourth word
      wr(8'h20, 8'h11); wr(8'h21, 8'h0F); wr(8'h21, 8'h04); wr(8'h21, 8'h01);
      wr(8'hA0, 8'h11); wr(8'hA1, 8'h73); wr(8'hA1, 8'h02); wr(8'hA1, 8'h01);
      rd_chk(8'h21, 8'h00, "R1 mask untouched");
      // R9 accept line 0, vector 0x08
      req(16'h0001, 1);
      wr(8'h20, 8'h0B);
      rd_chk(8'h20, 8'h01, "R7 isr readback");
      rd_chk(8'h20, 8'h00, "R7 second read zero");
      req(16'h0001, 1);                      // R9 busy refusal
      req(16'h0004, 1);                      // R9 cascade line refusal
      wr(8'h20, 8'h60);                      // R8 specific end of service line 0
      wr(8'h20, 8'h0B);
      rd_chk(8'h20, 8'h00, "R8 specific clear");
      // R12 simultaneous primary line 1 and secondary line 3
      req(16'h0802, 2);
      wr(8'hA0, 8'h0B);
      rd_chk(8'hA0, 8'h08, "R10 secondary isr");
      wr(8'hA0, 8'h20);                      // R8 clear all
      wr(8'h20, 8'h20);
      wr(8'hA0, 8'h0B);
      rd_chk(8'hA0, 8'h00, "R8 clear all");
      // R6 mask
      wr(8'h21, 8'h10);
      rd_chk(8'h21, 8'h10, "R6 mask read");
      req(16'h0010, 1);
      req(16'h0020, 1);
      // R7 other query value has no effect
      wr(8'h20, 8'h0A);
      rd_chk(8'h20, 8'h00, "R7 non-arming value");
      // R10 inconsistent secondary cascade word blocks secondary lines
      wr(8'hA0, 8'h11); wr(8'hA1, 8'h70); wr(8'hA1, 8'h03); wr(8'hA1, 8'h01);
      req(16'h1000, 2);
      // R5 R11 auto end of service, held request retriggers
      wr(8'hA0, 8'h11); wr(8'hA1, 8'h70); wr(8'hA1, 8'h02); wr(8'hA1, 8'h03);
      req(16'h1000, 5);
      wr(8'hA0, 8'h0B);
      rd_chk(8'hA0, 8'h00, "R11 auto cleared");
      // R3 single mode without fourth word on primary
      wr(8'h20, 8'h12); wr(8'h21, 8'h27); wr(8'h21, 8'h5A);
      rd_chk(8'h21, 8'h5A, "R3 mask after base");
      req(16'h0008, 1);
      // R4 cascade without fourth word on secondary
      wr(8'hA0, 8'h10); wr(8'hA1, 8'h78); wr(8'hA1, 8'h02); wr(8'hA1, 8'h81);
      rd_chk(8'hA1, 8'h81, "R4 mask after cascade");
      req(16'h0400, 1);
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule